// File: doc/BRIEF.md
# Banked Multi-Master RAM Arbiter

This block owns a small on-chip RAM split into equal banks and arbitrates six requesters in front of it. The requesters are two debug-side ports, a DMA port, a CPU port and two capture ports that only write. Bank arbitration is independent. Requesters that address different banks in the same cycle are all granted and served together. Requesters that collide in one bank are resolved by a fixed priority.

A requester holds its request, address, write enable, write data and byte enables stable until it sees a grant. The grant is combinational in the same cycle, and the access completes at the next rising clock edge. A losing requester keeps its request asserted and is considered again on the following cycle. A granted read returns its data one cycle later, marked by a single-cycle valid pulse on that requester's own return lane.

The storage is modelled as registers inside each bank. Each bank holds `2**IDX_W` 32-bit words. Address bits above the word index and below the bank field alias onto the same word.

Top module: `bank_ram_arbiter`

## Requirements
- R1: The bank is taken from byte address bits [15:14], which gives four banks by default. The word inside a bank is taken from address bits [5:2]. All other address bits do not affect which word is accessed.
- R2: In any cycle, at most one requester is granted per bank. A requester is never granted unless its request is asserted.
- R3: Within one bank the winner is the asserted requester with the lowest index. The index order is debug 0 (index 0), debug 1 (1), DMA (2), CPU (3), capture A (4), capture B (5). When both debug ports collide, debug 0 therefore wins.
- R4: Requesters that target different banks in the same cycle are all granted in that cycle.
- R5: The grant appears combinationally in the request cycle. A requester that loses and keeps requesting is granted in the first cycle in which no higher-ranked requester addresses its bank.
- R6: A granted read (write enable 0, index 0 to 3) produces a one-cycle `m_rvalid` pulse on that requester's lane only, in the cycle after the grant. `m_rdata` on that lane then holds the word as it was before that clock edge.
- R7: A granted write updates only the bytes whose enable bit is set. Enable bit k selects data bits [8k+7:8k].
- R8: Capture requesters (index 4 and 5) always perform writes whatever their write-enable input says, and their `m_rvalid` never asserts.
- R9: After reset every stored word reads as zero, and no `m_rvalid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 6 | Request, one bit per requester |
| m_we | input | 6 | Write enable per requester (ignored for index 4 and 5) |
| m_addr | input | 96 | Byte address, 16 bits per requester, requester i at [16i+15:16i] |
| m_wdata | input | 192 | Write data, 32 bits per requester |
| m_be | input | 24 | Byte enables, 4 bits per requester |
| m_gnt | output | 6 | Combinational grant per requester |
| m_rvalid | output | 6 | Read-return valid pulse per requester |
| m_rdata | output | 192 | Read-return data, 32 bits per requester |

## Verification
A wrong priority decision or a bad bank decode shows up on `m_gnt` in the same cycle as the request, because the grant has no register. A corrupted stored word, a byte written without its enable, or a write lost during a collision stays hidden until that word is read back. The fault then shows on `m_rdata` one cycle after the read grant. A valid pulse routed to the wrong lane, or a return register that never clears, shows on `m_rvalid` one cycle after the grant.

// File: rtl/bra_pkg.sv
package bra_pkg;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int N_MST    = 6;
    localparam int MST_DBG0 = 0;
    localparam int MST_DBG1 = 1;
    localparam int MST_DMA  = 2;
    localparam int MST_CPU  = 3;
    localparam int MST_CAPA = 4;
    localparam int MST_CAPB = 5;

    function automatic logic is_capture(input int idx);
        return (idx >= MST_CAPA);
    endfunction
endpackage

// File: rtl/bra_addr_decode.sv
module bra_addr_decode #(
    parameter int ADDR_W   = 16,
    parameter int BANK_LSB = 14,
    parameter int BANK_W   = 2,
    parameter int IDX_LSB  = 2,
    parameter int IDX_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [IDX_W-1:0]  idx
);
    logic unused_addr;

    assign bank        = addr[BANK_LSB +: BANK_W];
    assign idx         = addr[IDX_LSB +: IDX_W];
    assign unused_addr = ^addr;
endmodule

// File: rtl/bra_prio_pick.sv
module bra_prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bra_bank_store.sv
module bra_bank_store
    import bra_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [BE_W-1:0]   acc_be,
    output logic [DATA_W-1:0] acc_rdata
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] word;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc_en && acc_we) begin
            for (int k = 0; k < BE_W; k++) begin
                if (acc_be[k]) begin
                    st_d.word[acc_idx][k*8 +: 8] = acc_wdata[k*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rdata = st_q.word[acc_idx];
endmodule

// File: rtl/bank_ram_arbiter.sv
module bank_ram_arbiter
    import bra_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BANK_LSB = 14,
    parameter int BANK_W   = 2,
    parameter int IDX_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_MST-1:0]         m_req,
    input  logic [N_MST-1:0]         m_we,
    input  logic [N_MST*ADDR_W-1:0]  m_addr,
    input  logic [N_MST*DATA_W-1:0]  m_wdata,
    input  logic [N_MST*BE_W-1:0]    m_be,
    output logic [N_MST-1:0]         m_gnt,
    output logic [N_MST-1:0]         m_rvalid,
    output logic [N_MST*DATA_W-1:0]  m_rdata
);
    localparam int N_BANK  = 1 << BANK_W;
    localparam int IDX_LSB = 2;

    typedef struct packed {
        logic [N_MST-1:0]        rvalid;
        logic [N_MST*DATA_W-1:0] rdata;
    } ret_t;

    logic [BANK_W-1:0] mst_bank [N_MST];
    logic [IDX_W-1:0]  mst_idx  [N_MST];
    logic [N_MST-1:0]  mst_we_eff;
    logic [N_MST-1:0]  bank_hit [N_BANK];
    logic [N_MST-1:0]  bank_gnt [N_BANK];

    logic              bk_en    [N_BANK];
    logic              bk_we    [N_BANK];
    logic [IDX_W-1:0]  bk_idx   [N_BANK];
    logic [DATA_W-1:0] bk_wdata [N_BANK];
    logic [BE_W-1:0]   bk_be    [N_BANK];
    logic [DATA_W-1:0] bk_rdata [N_BANK];

    ret_t ret_d, ret_q;

    // Per-requester address split and effective direction
    for (genvar m = 0; m < N_MST; m++) begin : g_mst
        bra_addr_decode #(
            .ADDR_W  (ADDR_W),
            .BANK_LSB(BANK_LSB),
            .BANK_W  (BANK_W),
            .IDX_LSB (IDX_LSB),
            .IDX_W   (IDX_W)
        ) u_dec (
            .addr(m_addr[m*ADDR_W +: ADDR_W]),
            .bank(mst_bank[m]),
            .idx (mst_idx[m])
        );
        if (m >= MST_CAPA) begin : g_cap
            assign mst_we_eff[m] = 1'b1;
        end else begin : g_rw
            assign mst_we_eff[m] = m_we[m];
        end
    end

    // Per-bank request vectors, fixed-priority pick and storage
    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        always_comb begin
            for (int m = 0; m < N_MST; m++) begin
                bank_hit[b][m] = m_req[m] && (mst_bank[m] == BANK_W'(b));
            end
        end

        bra_prio_pick #(.N(N_MST)) u_pick (
            .req(bank_hit[b]),
            .gnt(bank_gnt[b])
        );

        always_comb begin
            bk_en[b]    = 1'b0;
            bk_we[b]    = 1'b0;
            bk_idx[b]   = '0;
            bk_wdata[b] = '0;
            bk_be[b]    = '0;
            for (int m = 0; m < N_MST; m++) begin
                if (bank_gnt[b][m]) begin
                    bk_en[b]    = 1'b1;
                    bk_we[b]    = mst_we_eff[m];
                    bk_idx[b]   = mst_idx[m];
                    bk_wdata[b] = m_wdata[m*DATA_W +: DATA_W];
                    bk_be[b]    = m_be[m*BE_W +: BE_W];
                end
            end
        end

        bra_bank_store #(.IDX_W(IDX_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_en   (bk_en[b]),
            .acc_we   (bk_we[b]),
            .acc_idx  (bk_idx[b]),
            .acc_wdata(bk_wdata[b]),
            .acc_be   (bk_be[b]),
            .acc_rdata(bk_rdata[b])
        );
    end

    // Grant collection across banks
    always_comb begin
        m_gnt = '0;
        for (int b = 0; b < N_BANK; b++) begin
            m_gnt = m_gnt | bank_gnt[b];
        end
    end

    // Read return lanes
    always_comb begin
        ret_d        = ret_q;
        ret_d.rvalid = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (m_gnt[m] && !mst_we_eff[m]) begin
                ret_d.rvalid[m]                  = 1'b1;
                ret_d.rdata[m*DATA_W +: DATA_W] = bk_rdata[mst_bank[m]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else begin
            ret_q <= ret_d;
        end
    end

    assign m_rvalid = ret_q.rvalid;
    assign m_rdata  = ret_q.rdata;
endmodule

// File: rtl/bra_checker.sv
module bra_checker
    import bra_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BANK_LSB = 14,
    parameter int BANK_W   = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_MST-1:0]        m_req,
    input logic [N_MST-1:0]        m_we,
    input logic [N_MST*ADDR_W-1:0] m_addr,
    input logic [N_MST-1:0]        m_gnt,
    input logic [N_MST-1:0]        m_rvalid
);
    logic [BANK_W-1:0] ck_bank [N_MST];
    logic [N_MST-1:0]  ck_blocked;
    logic              unused_bits;

    assign unused_bits = ^m_addr;

    always_comb begin
        for (int m = 0; m < N_MST; m++) begin
            ck_bank[m] = m_addr[m*ADDR_W + BANK_LSB +: BANK_W];
        end
        for (int m = 0; m < N_MST; m++) begin
            ck_blocked[m] = 1'b0;
            for (int j = 0; j < m; j++) begin
                if (m_req[j] && ck_bank[j] == ck_bank[m]) begin
                    ck_blocked[m] = 1'b1;
                end
            end
        end
    end

    for (genvar m = 0; m < N_MST; m++) begin : g_one
        a_r2_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
            m_gnt[m] |-> m_req[m]);

        a_r4_free_bank_served: assert property (@(posedge clk) disable iff (!rst_n)
            (m_req[m] && !ck_blocked[m]) |-> m_gnt[m]);

        if (m >= MST_CAPA) begin : g_cap
            a_r8_capture_silent: assert property (@(posedge clk) disable iff (!rst_n)
                !m_rvalid[m]);
        end else begin : g_rd
            a_r6_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
                (m_gnt[m] && !m_we[m]) |=> m_rvalid[m]);
            a_r6_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
                !(m_gnt[m] && !m_we[m]) |=> !m_rvalid[m]);
        end

        for (genvar j = m + 1; j < N_MST; j++) begin : g_pair
            a_r2_one_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
                (m_gnt[m] && m_gnt[j]) |-> (ck_bank[m] != ck_bank[j]));
            a_r3_higher_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (m_req[m] && m_req[j] && ck_bank[m] == ck_bank[j]) |-> !m_gnt[j]);
        end
    end
endmodule

bind bank_ram_arbiter bra_checker #(
    .ADDR_W  (ADDR_W),
    .BANK_LSB(BANK_LSB),
    .BANK_W  (BANK_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_addr  (m_addr),
    .m_gnt   (m_gnt),
    .m_rvalid(m_rvalid)
);

// File: tb/sim_bank_ram_arbiter.sv
module sim_bank_ram_arbiter;
    import bra_pkg::*;

    localparam int AW = 16;
    localparam int NB = 4;
    localparam int NW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N_MST-1:0]     m_req = '0;
    logic [N_MST-1:0]     m_we = '0;
    logic [N_MST*AW-1:0]  m_addr = '0;
    logic [N_MST*32-1:0]  m_wdata = '0;
    logic [N_MST*4-1:0]   m_be = '0;
    logic [N_MST-1:0]     m_gnt;
    logic [N_MST-1:0]     m_rvalid;
    logic [N_MST*32-1:0]  m_rdata;

    // shadow stimulus, applied at the falling edge inside step()
    logic [N_MST-1:0]     d_req = '0;
    logic [N_MST-1:0]     d_we = '0;
    logic [N_MST*AW-1:0]  d_addr = '0;
    logic [N_MST*32-1:0]  d_wdata = '0;
    logic [N_MST*4-1:0]   d_be = '0;

    logic [31:0]          ref_mem [NB][NW];
    logic [N_MST-1:0]     exp_rv = '0;
    logic [31:0]          exp_rd [N_MST];

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    bank_ram_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_be(m_be), .m_gnt(m_gnt), .m_rvalid(m_rvalid),
        .m_rdata(m_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] bank_of(input int m);
        return d_addr[m*AW + 14 +: 2];
    endfunction

    function automatic logic [3:0] idx_of(input int m);
        return d_addr[m*AW + 2 +: 4];
    endfunction

    task automatic set_m(input int m, input bit req, input bit we, input logic [15:0] a,
                         input logic [31:0] wd, input logic [3:0] be);
        d_req[m]           = req;
        d_we[m]            = we;
        d_addr[m*AW +: AW] = a;
        d_wdata[m*32 +: 32] = wd;
        d_be[m*4 +: 4]     = be;
    endtask

    task automatic idle_all();
        for (int m = 0; m < N_MST; m++) set_m(m, 0, 0, 16'h0, 32'h0, 4'h0);
    endtask

    // One bus cycle: check returns of the previous cycle, apply inputs, check grants
    task automatic step(input string tag);
        logic [N_MST-1:0] eg;
        @(negedge clk);
        check(m_rvalid == exp_rv, {tag, " R6/R8 rvalid"}, 64'(m_rvalid), 64'(exp_rv));
        for (int m = 0; m < N_MST; m++) begin
            if (exp_rv[m]) begin
                check(m_rdata[m*32 +: 32] == exp_rd[m], {tag, " R6 rdata"},
                      64'(m_rdata[m*32 +: 32]), 64'(exp_rd[m]));
            end
        end
        m_req = d_req; m_we = d_we; m_addr = d_addr; m_wdata = d_wdata; m_be = d_be;
        #1;
        for (int i = 0; i < N_MST; i++) begin
            eg[i] = d_req[i];
            for (int j = 0; j < i; j++) begin
                if (d_req[j] && bank_of(j) == bank_of(i)) eg[i] = 1'b0;
            end
        end
        check(m_gnt == eg, {tag, " R3/R4/R5 grant"}, 64'(m_gnt), 64'(eg));
        for (int i = 0; i < N_MST; i++) begin
            for (int j = i + 1; j < N_MST; j++) begin
                if (m_gnt[i] && m_gnt[j] && bank_of(i) == bank_of(j)) begin
                    check(1'b0, {tag, " R2 two grants in one bank"}, 64'(i), 64'(j));
                end
            end
        end
        for (int i = 0; i < N_MST; i++) begin
            exp_rv[i] = eg[i] && i < MST_CAPA && !d_we[i];
            if (exp_rv[i]) exp_rd[i] = ref_mem[bank_of(i)][idx_of(i)];
        end
        for (int i = 0; i < N_MST; i++) begin
            if (eg[i] && (i >= MST_CAPA || d_we[i])) begin
                for (int k = 0; k < 4; k++) begin
                    if (d_be[i*4 + k])
                        ref_mem[bank_of(i)][idx_of(i)][k*8 +: 8] = d_wdata[i*32 + k*8 +: 8];
                end
            end
        end
    endtask

    task automatic t_reset();
        for (int b = 0; b < NB; b++) for (int w = 0; w < NW; w++) ref_mem[b][w] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(m_rvalid == '0, "R9 rvalid in reset", 64'(m_rvalid), 64'h0);
        check(m_gnt == '0, "R2 no grant without request", 64'(m_gnt), 64'h0);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++) begin
            idle_all();
            set_m(MST_DMA, 1, 0, 16'(b << 14) | 16'h0024, 32'h0, 4'h0);
            step("R9 read after reset");
        end
        idle_all();
        step("R9 drain");
    endtask

    task automatic t_collide();
        for (int m = 0; m < N_MST; m++) set_m(m, 1, (m == 2), 16'h4008, 32'h1000 + m, 4'hF);
        for (int m = 0; m < N_MST; m++) begin
            step("R3 same-bank collision");
            check(m_gnt == N_MST'(1 << m), "R5 loser served next", 64'(m_gnt), 64'(1 << m));
            d_req[m] = 1'b0;
        end
        step("R3 drain");
    endtask

    task automatic t_parallel();
        idle_all();
        set_m(MST_DBG1, 1, 1, 16'h0004, 32'hA0A0A0A0, 4'hF);
        set_m(MST_DMA, 1, 1, 16'h4004, 32'hB1B1B1B1, 4'hF);
        set_m(MST_CPU, 1, 1, 16'h8004, 32'hC2C2C2C2, 4'hF);
        set_m(MST_CAPB, 1, 1, 16'hC004, 32'hD3D3D3D3, 4'hF);
        step("R4 four banks");
        check(m_gnt == 6'b101110, "R4 all granted", 64'(m_gnt), 64'h2E);
        idle_all();
        set_m(MST_DBG0, 1, 0, 16'h0004, 32'h0, 4'h0);
        set_m(MST_DBG1, 1, 0, 16'h4004, 32'h0, 4'h0);
        set_m(MST_DMA, 1, 0, 16'h8004, 32'h0, 4'h0);
        set_m(MST_CPU, 1, 0, 16'hC004, 32'h0, 4'h0);
        step("R4 parallel read");
        idle_all();
        step("R6 parallel return");
    endtask

    task automatic t_byte_en();
        idle_all();
        set_m(MST_CPU, 1, 1, 16'h8030, 32'h11223344, 4'hF);
        step("R7 full write");
        set_m(MST_CPU, 1, 1, 16'h8030, 32'hAABBCCDD, 4'b0101);
        step("R7 partial write");
        set_m(MST_CPU, 1, 0, 16'h8030, 32'h0, 4'h0);
        step("R7 read back");
        idle_all();
        step("R7 return");
        check(m_rdata[MST_CPU*32 +: 32] == 32'h11BB33DD, "R7 enabled bytes only",
              64'(m_rdata[MST_CPU*32 +: 32]), 64'h11BB33DD);
    endtask

    task automatic t_capture();
        idle_all();
        set_m(MST_CAPA, 1, 0, 16'h800C, 32'hCAFE0001, 4'hF);
        step("R8 capture with we low");
        idle_all();
        step("R8 no capture rvalid");
        check(m_rvalid == '0, "R8 capture silent", 64'(m_rvalid), 64'h0);
        set_m(MST_DBG0, 1, 0, 16'h800C, 32'h0, 4'h0);
        step("R8 read capture word");
        idle_all();
        step("R8 return");
        check(m_rdata[31:0] == 32'hCAFE0001, "R8 capture wrote", 64'(m_rdata[31:0]),
              64'hCAFE0001);
    endtask

    task automatic t_decode();
        idle_all();
        set_m(MST_DMA, 1, 1, 16'h7FC8, 32'h5EED0001, 4'hF);
        step("R1 write high alias");
        set_m(MST_DMA, 1, 0, 16'h4008, 32'h0, 4'h0);
        step("R1 read alias");
        idle_all();
        step("R1 return");
        check(m_rdata[MST_DMA*32 +: 32] == 32'h5EED0001, "R1 bits outside field ignored",
              64'(m_rdata[MST_DMA*32 +: 32]), 64'h5EED0001);
        set_m(MST_DMA, 1, 0, 16'h8008, 32'h0, 4'h0);
        step("R1 other bank");
        idle_all();
        step("R1 other bank return");
    endtask

    task automatic t_random();
        for (int n = 0; n < 400; n++) begin
            for (int m = 0; m < N_MST; m++) begin
                set_m(m, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                      16'($urandom), $urandom, 4'($urandom));
            end
            step("R2/R3 random");
        end
        idle_all();
        step("R6 random drain");
    endtask

    initial begin
        t_reset();
        t_collide();
        t_parallel();
        t_byte_en();
        t_capture();
        t_decode();
        t_random();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule